// File: doc/BRIEF.md
# Two-Pass Depthwise Separable Convolution Engine

This block computes one tile of a depthwise separable convolution layer. A tile of input pixels and its weight set arrive on two valid/ready streams. The engine then runs a spatial pass, which filters each channel on its own with a K x K kernel and writes the per-channel results into an on-chip intermediate buffer. After that buffer is complete, it runs a cross-channel pass that mixes the channels with 1x1 weights. Output pixels leave on a valid/ready stream. Both passes share one bank of signed multipliers. The active pass only changes which operands the multipliers receive.

Parallelism is fixed at compile time along three axes: channels per step, kernel positions per step and output filters per step. An output tile of TH x TW pixels needs an input tile of (TH+K-1) x (TW+K-1) pixels, because every border pixel is a valid convolution and no padding is added. The host splits the feature map into tiles that divide it exactly. The host sends the complete weight set again with every tile.

Top module: `dws_engine`

## Requirements
- R1: After reset the output valid is low, and both input streams are ready.
- R2: Input pixels are taken in the order row, column, channel, with (TH+K-1)*(TW+K-1)*C beats per tile. Weights are taken as C*K*K depthwise values (index channel*K*K + ky*K + kx), followed by F*C pointwise values (index C*K*K + filter*C + channel). Each input stream drops ready when its part of the tile is complete. Neither stream accepts a beat while the tile is being computed.
- R3: The spatial pass never sums across channels. Each intermediate value depends only on its own channel's pixels and kernel.
- R4: All results are exact for any signed input values, including all operands at the most negative code. The intermediate width is 2*DW+ceil(log2(K*K)) and the output width is that plus DW+ceil(log2(C)).
- R5: Outputs leave in the order row, column, filter group. A beat carries PF filters, and lane j (bits [j*OUT_W +: OUT_W]) holds filter group*PF+j as the signed sum over channels of pointwise weight times intermediate value.
- R6: The cross-channel pass starts only after the spatial pass has finished the whole tile. The first output of a tile comes no sooner than TH*TW*(C/PC)*(K*K/PK) + C/PC cycles after the last input beat.
- R7: While output valid is high and ready is low, the valid and data outputs hold their values, and no result is lost.
- R8: After the last output step of a tile, the engine accepts a new tile with new weights and produces correct results for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input pixel beat valid |
| pix_data_i | input | DW | Signed input pixel |
| pix_ready_o | output | 1 | Engine can take a pixel |
| wgt_valid_i | input | 1 | Weight beat valid |
| wgt_data_i | input | DW | Signed weight |
| wgt_ready_o | output | 1 | Engine can take a weight |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | PF*OUT_W | PF signed output lanes |
| out_ready_i | input | 1 | Downstream accepts output |

## Verification
The assertions check the following on every cycle. The output holds while it is stalled. The cross-channel pass is entered only from the spatial pass. A new tile returns to loading only from the cross-channel pass. Computation starts only when both input buffers are full. The bench scenarios alone show that the arithmetic is correct: exact sums at extreme codes, isolation of each channel, lane and beat ordering, and the minimum latency before the first output. For this the bench runs tiles with random values, random gaps and random backpressure, and compares every beat with a reference model.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_DW   = 2'd1,
    ST_PW   = 2'd2
  } phase_e;
endpackage

// File: rtl/dws_seq.sv
module dws_seq
  import dws_pkg::*;
#(
  parameter int TH = 4,
  parameter int TW = 4,
  parameter int DG = 2,
  parameter int DI = 3,
  parameter int PG = 2,
  parameter int PI = 2,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  output phase_e        phase_o,
  output logic [CW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic [CW-1:0] grp_o,
  output logic [CW-1:0] inr_o,
  output logic          step_o,
  output logic          first_o,
  output logic          last_o
);
  logic [CW-1:0] glim, ilim;
  logic last_g, last_c, last_r;

  always_comb begin
    glim    = (phase_o == ST_PW) ? CW'(PG - 1) : CW'(DG - 1);
    ilim    = (phase_o == ST_PW) ? CW'(PI - 1) : CW'(DI - 1);
    step_o  = (phase_o == ST_DW) || (phase_o == ST_PW && adv_i);
    first_o = (inr_o == '0);
    last_o  = (inr_o == ilim);
    last_g  = (grp_o == glim);
    last_c  = (col_o == CW'(TW - 1));
    last_r  = (row_o == CW'(TH - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= ST_LOAD;
      row_o   <= '0;
      col_o   <= '0;
      grp_o   <= '0;
      inr_o   <= '0;
    end else if (phase_o == ST_LOAD) begin
      if (start_i) begin
        phase_o <= ST_DW;
        row_o   <= '0;
        col_o   <= '0;
        grp_o   <= '0;
        inr_o   <= '0;
      end
    end else if (step_o) begin
      if (!last_o) inr_o <= inr_o + 1'b1;
      else begin
        inr_o <= '0;
        if (!last_g) grp_o <= grp_o + 1'b1;
        else begin
          grp_o <= '0;
          if (!last_c) col_o <= col_o + 1'b1;
          else begin
            col_o <= '0;
            if (!last_r) row_o <= row_o + 1'b1;
            else begin
              row_o   <= '0;
              phase_o <= (phase_o == ST_DW) ? ST_PW : ST_LOAD;
            end
          end
        end
      end
    end
  end

  // pointwise entered only from a finished depthwise pass
  p_pw_after_dw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o == ST_PW) |-> $past(phase_o == ST_DW));
  p_load_after_pw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o == ST_LOAD) |-> $past(phase_o == ST_PW));
endmodule

// File: rtl/dws_mul_bank.sv
module dws_mul_bank #(
  parameter int N    = 6,
  parameter int AW   = 20,
  parameter int BW   = 8,
  parameter int PW_W = AW + BW
) (
  input  logic                      sel_pw_i,
  input  logic [N-1:0][BW-1:0]      dw_a_i,
  input  logic [N-1:0][BW-1:0]      dw_b_i,
  input  logic [N-1:0][AW-1:0]      pw_a_i,
  input  logic [N-1:0][BW-1:0]      pw_b_i,
  output logic [N-1:0][PW_W-1:0]    prod_o
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic signed [AW-1:0]   a;
    logic signed [BW-1:0]   b;
    logic signed [PW_W-1:0] ax, bx;
    // routing is the only pass-dependent part
    assign a  = sel_pw_i ? $signed(pw_a_i[i]) : AW'($signed(dw_a_i[i]));
    assign b  = sel_pw_i ? $signed(pw_b_i[i]) : $signed(dw_b_i[i]);
    assign ax = PW_W'(a);
    assign bx = PW_W'(b);
    assign prod_o[i] = ax * bx;
  end
endmodule

// File: rtl/dws_engine.sv
module dws_engine
  import dws_pkg::*;
#(
  parameter int DW = 8,
  parameter int C  = 4,
  parameter int F  = 4,
  parameter int K  = 3,
  parameter int TH = 4,
  parameter int TW = 4,
  parameter int PC = 2,
  parameter int PF = 2,
  parameter int PK = 3,
  localparam int KK     = K * K,
  localparam int MID_W  = 2 * DW + $clog2(KK),
  localparam int PROD_W = MID_W + DW,
  localparam int OUT_W  = PROD_W + $clog2(C)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pix_valid_i,
  input  logic [DW-1:0]       pix_data_i,
  output logic                pix_ready_o,
  input  logic                wgt_valid_i,
  input  logic [DW-1:0]       wgt_data_i,
  output logic                wgt_ready_o,
  output logic                out_valid_o,
  output logic [PF*OUT_W-1:0] out_data_o,
  input  logic                out_ready_i
);
  localparam int ITW  = TW + K - 1;
  localparam int NPIX = (TH + K - 1) * ITW * C;
  localparam int NW   = C * KK + F * C;
  localparam int NIMB = TH * TW * C;
  localparam int NDW  = PC * PK;
  localparam int NPW  = PF * PC;
  localparam int NMUL = (NDW > NPW) ? NDW : NPW;
  localparam int CW   = $clog2(NPIX + NW) + 1;

  phase_e phase;
  logic [CW-1:0] row, col, grp, inr, pix_cnt, wgt_cnt;
  logic step, first, last, start, adv;

  logic signed [DW-1:0]    pix_mem [NPIX];
  logic signed [DW-1:0]    wgt_mem [NW];
  logic signed [MID_W-1:0] imb     [NIMB];

  logic [NMUL-1:0][DW-1:0]     dw_a, dw_b, pw_b;
  logic [NMUL-1:0][MID_W-1:0]  pw_a;
  logic [NMUL-1:0][PROD_W-1:0] prod;

  logic signed [MID_W-1:0] dw_acc [PC];
  logic signed [MID_W-1:0] dw_sum [PC];
  logic signed [OUT_W-1:0] pw_acc [PF];
  logic [PF-1:0][OUT_W-1:0] pw_sum;
  logic [PF*OUT_W-1:0]      out_q;
  logic                     out_v;

  // ---- tile load ----
  assign pix_ready_o = (phase == ST_LOAD) && (pix_cnt != CW'(NPIX));
  assign wgt_ready_o = (phase == ST_LOAD) && (wgt_cnt != CW'(NW));
  assign start       = (phase == ST_LOAD) && (pix_cnt == CW'(NPIX)) && (wgt_cnt == CW'(NW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_cnt <= '0;
      wgt_cnt <= '0;
    end else if (start) begin
      pix_cnt <= '0;
      wgt_cnt <= '0;
    end else begin
      if (pix_valid_i && pix_ready_o) pix_cnt <= pix_cnt + 1'b1;
      if (wgt_valid_i && wgt_ready_o) wgt_cnt <= wgt_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (pix_valid_i && pix_ready_o) pix_mem[pix_cnt] <= $signed(pix_data_i);
    if (wgt_valid_i && wgt_ready_o) wgt_mem[wgt_cnt] <= $signed(wgt_data_i);
  end

  // ---- sequencing ----
  assign adv = !out_v || out_ready_i;

  dws_seq #(
    .TH(TH), .TW(TW), .DG(C / PC), .DI(KK / PK), .PG(F / PF), .PI(C / PC), .CW(CW)
  ) i_seq (
    .clk_i, .rst_ni, .start_i(start), .adv_i(adv), .phase_o(phase),
    .row_o(row), .col_o(col), .grp_o(grp), .inr_o(inr),
    .step_o(step), .first_o(first), .last_o(last)
  );

  // ---- operand routing per lane ----
  for (genvar l = 0; l < NMUL; l++) begin : g_op
    if (l < NDW) begin : g_dw
      always_comb begin
        int ch, kid, ky, kx;
        ch  = int'(grp) * PC + l / PK;
        kid = int'(inr) * PK + l % PK;
        ky  = kid / K;
        kx  = kid % K;
        dw_a[l] = pix_mem[((int'(row) + ky) * ITW + int'(col) + kx) * C + ch];
        dw_b[l] = wgt_mem[ch * KK + kid];
      end
    end else begin : g_dw0
      assign dw_a[l] = '0;
      assign dw_b[l] = '0;
    end
    if (l < NPW) begin : g_pw
      always_comb begin
        int ch, f;
        f  = int'(grp) * PF + l / PC;
        ch = int'(inr) * PC + l % PC;
        pw_a[l] = imb[(int'(row) * TW + int'(col)) * C + ch];
        pw_b[l] = wgt_mem[C * KK + f * C + ch];
      end
    end else begin : g_pw0
      assign pw_a[l] = '0;
      assign pw_b[l] = '0;
    end
  end

  dws_mul_bank #(.N(NMUL), .AW(MID_W), .BW(DW), .PW_W(PROD_W)) i_mul (
    .sel_pw_i(phase == ST_PW), .dw_a_i(dw_a), .dw_b_i(dw_b),
    .pw_a_i(pw_a), .pw_b_i(pw_b), .prod_o(prod)
  );

  // ---- depthwise: per-channel sums, never across channels ----
  for (genvar c = 0; c < PC; c++) begin : g_dwacc
    always_comb begin
      logic signed [MID_W-1:0] s;
      s = first ? '0 : dw_acc[c];
      for (int k = 0; k < PK; k++) s = s + $signed(prod[c * PK + k][MID_W-1:0]);
      dw_sum[c] = s;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dw_acc[c] <= '0;
      else if (step && phase == ST_DW) dw_acc[c] <= dw_sum[c];
    end
  end

  always_ff @(posedge clk_i) begin
    if (step && phase == ST_DW && last)
      for (int c = 0; c < PC; c++)
        imb[(int'(row) * TW + int'(col)) * C + int'(grp) * PC + c] <= dw_sum[c];
  end

  // ---- pointwise: sum channel groups per filter ----
  for (genvar f = 0; f < PF; f++) begin : g_pwacc
    always_comb begin
      logic signed [OUT_W-1:0] s;
      s = first ? '0 : pw_acc[f];
      for (int c = 0; c < PC; c++) s = s + OUT_W'($signed(prod[f * PC + c]));
      pw_sum[f] = s;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pw_acc[f] <= '0;
      else if (step && phase == ST_PW) pw_acc[f] <= pw_sum[f];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v <= 1'b0;
      out_q <= '0;
    end else if (step && phase == ST_PW && last) begin
      out_v <= 1'b1;
      out_q <= pw_sum;
    end else if (out_ready_i) begin
      out_v <= 1'b0;
    end
  end

  assign out_valid_o = out_v;
  assign out_data_o  = out_q;

  p_hold_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);
  p_hold_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o));
  p_full_at_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase == ST_DW) |-> $past(pix_cnt == CW'(NPIX) && wgt_cnt == CW'(NW)));
  p_no_take_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != ST_LOAD) |=> $stable(pix_cnt) && $stable(wgt_cnt));
endmodule

// File: tb/test_dws_engine.sv
module test_dws_engine;
  localparam int DW = 8, C = 4, F = 4, K = 3, TH = 4, TW = 4, PC = 2, PF = 2, PK = 3;
  localparam int KK = K * K;
  localparam int OUT_W = 2 * DW + $clog2(KK) + DW + $clog2(C);
  localparam int ITW = TW + K - 1;
  localparam int NPIX = (TH + K - 1) * ITW * C;
  localparam int NW = C * KK + F * C;
  localparam int FG = F / PF;
  localparam int NBEAT = TH * TW * FG;
  localparam int MIN_LAT = TH * TW * (C / PC) * (KK / PK) + C / PC;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, wgt_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] pix_data = '0, wgt_data = '0;
  logic pix_ready, wgt_ready, out_valid;
  logic [PF*OUT_W-1:0] out_data;

  always #4 clk = ~clk;

  dws_engine #(.DW(DW), .C(C), .F(F), .K(K), .TH(TH), .TW(TW), .PC(PC), .PF(PF), .PK(PK))
    i_dws_engine (
      .clk_i(clk), .rst_ni(rst_n),
      .pix_valid_i(pix_valid), .pix_data_i(pix_data), .pix_ready_o(pix_ready),
      .wgt_valid_i(wgt_valid), .wgt_data_i(wgt_data), .wgt_ready_o(wgt_ready),
      .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready));

  int checks = 0, errors = 0, cyc = 0;
  bit wd = 0;
  int tp [NPIX];
  int tw [NW];

  function automatic longint ref_out(int r, int c, int f);
    longint acc = 0;
    for (int ch = 0; ch < C; ch++) begin
      longint d = 0;
      for (int ky = 0; ky < K; ky++)
        for (int kx = 0; kx < K; kx++)
          d += longint'(tp[((r + ky) * ITW + c + kx) * C + ch]) * tw[ch * KK + ky * K + kx];
      acc += d * tw[C * KK + f * C + ch];
    end
    return acc;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd_val(int mode);
    case (mode)
      0: return -128;
      2: return ($urandom % 2) ? 127 : -128;
      default: return int'($urandom % 256) - 128;
    endcase
  endfunction

  task automatic run_tile(int mode, int t);
    int pi = 0, wi = 0, ob = 0, ld = -1, first_c = -1;
    bit ph = 0, wh = 0, stall = 0, busy_bad = 0;
    logic [PF*OUT_W-1:0] prev;
    string req;
    for (int i = 0; i < NPIX; i++)
      tp[i] = (mode == 1 && (i % C) != 2) ? 0 : rnd_val(mode);
    for (int i = 0; i < NW; i++) tw[i] = rnd_val(mode);
    req = (mode == 0 || mode == 2) ? "R4" : (mode == 1) ? "R3" : "R5";
    while (ob < NBEAT && !wd) begin
      @(negedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        wd = 1;
        chk(0, "watchdog", cyc, LIMIT);
        break;
      end
      if (ph) pi++;
      if (wh) wi++;
      if (stall) begin
        chk(out_valid === 1'b1, "R7", longint'(out_valid), 1);
        chk(out_data === prev, "R7", longint'(out_data[OUT_W-1:0]), longint'(prev[OUT_W-1:0]));
      end
      pix_valid = (pi < NPIX) && ($urandom % 4 != 0);
      pix_data  = (pi < NPIX) ? DW'(tp[pi]) : '0;
      wgt_valid = (wi < NW) && ($urandom % 4 != 0);
      wgt_data  = (wi < NW) ? DW'(tw[wi]) : '0;
      out_ready = (mode == 0) ? 1'b1 : 1'($urandom % 2);
      if (pi == NPIX && wi == NW && ld < 0) ld = cyc;
      #1;
      if (ld >= 0 && first_c < 0 && (pix_ready || wgt_ready)) busy_bad = 1;
      ph = pix_valid && pix_ready;
      wh = wgt_valid && wgt_ready;
      if (out_valid && out_ready) begin
        if (ob == 0) begin
          first_c = cyc;
          chk(ld >= 0 && (cyc - ld) >= MIN_LAT, "R6", cyc - ld, MIN_LAT);
        end
        for (int j = 0; j < PF; j++) begin
          longint got, exp;
          int pix = ob / FG;
          got = longint'($signed(out_data[j*OUT_W +: OUT_W]));
          exp = ref_out(pix / TW, pix % TW, (ob % FG) * PF + j);
          chk(got == exp, req, got, exp);
        end
        ob++;
      end
      stall = out_valid && !out_ready;
      prev  = out_data;
    end
    chk(!busy_bad, "R2", longint'(busy_bad), 0);
    if (t > 0) chk(ob == NBEAT, "R8", ob, NBEAT);
    pix_valid = 0;
    wgt_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
    chk(pix_ready === 1'b1 && wgt_ready === 1'b1, "R1", longint'({pix_ready, wgt_ready}), 3);
    run_tile(0, 0);
    run_tile(1, 1);
    run_tile(2, 2);
    for (int t = 3; t < 7; t++) if (!wd) run_tile(3, t);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule